// File: doc/BRIEF.md
# Pipelined Table-Lookup Multiplier

This unit scales a 12-bit unsigned data operand by a coefficient that it fetches from an internal constant table. A 9-bit index picks one of 512 coefficients. The table holds one quarter of a sine-like curve, built as a parabola and scaled to 12 bits. The table is split into three 4-bit slices that are all read with the same index. The coefficient is multiplied by the operand in an array of small 2-bit by 4-bit multiply-accumulate cells. The cells are arranged in offset rows, as in long-hand multiplication.

The operand is divided into a low half and a high half, and each half has its own 12x6 sub-array. The two half-products are registered. A final adder row then combines them, with the high half weighted by 64. An XOR row can complement the whole 24-bit result word. The invert control is captured together with each set of operands, so a stream of transactions can mix inverted and plain results on consecutive cycles. A new transaction can be accepted on every cycle, and each result appears a fixed three cycles after it was issued.

Top module: `lut_mult`

## Requirements
- R1: Table entry i (0 to 511) equals floor(i*(1024-i)*4095/262144). Entry 0 is 0 and entry 511 is 4094, so an operand of 1 returns the entry itself.
- R2: With inv_i low, res_o is the unsigned 24-bit product of the table entry selected by idx_i and op_i. This includes an operand of 4095.
- R3: With inv_i high, res_o is the bitwise complement of that 24-bit product, with all 24 bits flipped.
- R4: vld_o is high in exactly those cycles that come three rising edges after a rising edge that sampled vld_i high. It is low in all other cycles, including when vld_i has gaps.
- R5: A transaction is accepted on every cycle. Each result uses the inv_i value that was sampled with its own idx_i and op_i, even when inv_i alternates every cycle.
- R6: When rst_ni is low, vld_o and res_o are forced to 0 at once, without waiting for a clock edge.
- R7: Index 0 gives a product of 0 for any operand: res_o is all zeros, or all ones when inverted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Transaction strobe for idx_i, op_i and inv_i |
| idx_i | input | 9 | Coefficient table index |
| op_i | input | 12 | Unsigned data operand |
| inv_i | input | 1 | Complement all result bits for this transaction |
| res_o | output | 24 | Product, or its complement |
| vld_o | output | 1 | res_o carries a new result |

## Verification
Every result is due on the third rising edge after the edge that sampled its inputs: one edge for the table read, one for the half-products and one for the sum and invert. The bench drives inputs on the falling edge and keeps a three-entry shift register of expected valid flags, results and requirement tags. On each falling edge it compares the outputs with the oldest entry before it shifts in the new transaction, so every check falls exactly three edges after its stimulus. The asynchronous clear is checked one time unit after reset falls in the middle of a run, with no clock edge in between. After that the expected pipeline is emptied.

// File: rtl/lm_pkg.sv
package lm_pkg;

  // quarter-wave shape: parabola peaking at depth, scaled to 2**cw-1
  function automatic logic [31:0] lut_val(int i, int depth, int cw);
    longint v;
    v = longint'(i) * longint'(2 * depth - i);
    v = (v * ((longint'(1) << cw) - 1)) / (longint'(depth) * longint'(depth));
    return 32'(v);
  endfunction

endpackage

// File: rtl/lm_rom.sv
module lm_rom #(
  parameter int IDX_W = 9,
  parameter int CW    = 12,
  parameter int SW    = 4
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [CW-1:0]    coef_o
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int NSL   = CW / SW;

  function automatic logic [DEPTH*SW-1:0] fill(int s);
    logic [DEPTH*SW-1:0] r;
    logic [31:0] t;
    r = '0;
    for (int i = 0; i < DEPTH; i++) begin
      t = lm_pkg::lut_val(i, DEPTH, CW);
      r[i*SW +: SW] = t[s*SW +: SW];
    end
    return r;
  endfunction

  logic [31:0] base;
  assign base = 32'(idx_i) * SW;

  for (genvar s = 0; s < NSL; s++) begin : gen_slice
    localparam logic [DEPTH*SW-1:0] TBL = fill(s);
    assign coef_o[s*SW +: SW] = TBL[base +: SW];
  end

endmodule

// File: rtl/lm_cell.sv
// 4b x 2b product plus 4b partial sum plus 2b carry; max 63
module lm_cell (
  input  logic [3:0] a_i,
  input  logic [1:0] b_i,
  input  logic [3:0] s_i,
  input  logic [1:0] c_i,
  output logic [3:0] s_o,
  output logic [1:0] c_o
);
  logic [5:0] acc;
  assign acc = ({2'b00, a_i} * {4'b0000, b_i}) + {2'b00, s_i} + {4'b0000, c_i};
  assign {c_o, s_o} = acc;
endmodule

// File: rtl/lm_row.sv
// one long-hand row: p_o = p_i + (a_i * b_i) << SH
module lm_row #(
  parameter int AW = 12,
  parameter int PW = 18,
  parameter int SH = 0
) (
  input  logic [AW-1:0] a_i,
  input  logic [1:0]    b_i,
  input  logic [PW-1:0] p_i,
  output logic [PW-1:0] p_o
);
  localparam int NC  = AW / 4;
  localparam int TOP = SH + AW + 2;

  for (genvar j = 0; j < NC; j++) begin : gen_cell
    logic [1:0] cin, cout;
    logic [3:0] sum;
    if (j == 0) begin : g_first
      assign cin = 2'b00;
    end else begin : g_next
      assign cin = gen_cell[j-1].cout;
    end
    lm_cell u_cell (
      .a_i(a_i[4*j +: 4]),
      .b_i(b_i),
      .s_i(p_i[SH+4*j +: 4]),
      .c_i(cin),
      .s_o(sum),
      .c_o(cout)
    );
    assign p_o[SH+4*j +: 4] = sum;
  end

  assign p_o[TOP-1 -: 2] = gen_cell[NC-1].cout;

  if (SH > 0) begin : g_low
    assign p_o[SH-1:0] = p_i[SH-1:0];
  end
  if (TOP < PW) begin : g_high
    assign p_o[PW-1:TOP] = '0;
  end

  // incoming partial sum never reaches past this row's window
  always_comb begin
    a_r2_row_headroom: assert ((p_i >> (SH + AW)) == '0)
      else $error("row partial sum overflow");
  end

endmodule

// File: rtl/lm_half.sv
module lm_half #(
  parameter int AW = 12,
  parameter int BW = 6
) (
  input  logic [AW-1:0]    a_i,
  input  logic [BW-1:0]    b_i,
  output logic [AW+BW-1:0] p_o
);
  localparam int PW = AW + BW;
  localparam int NR = BW / 2;

  for (genvar r = 0; r < NR; r++) begin : gen_row
    logic [PW-1:0] pin, pout;
    if (r == 0) begin : g_first
      assign pin = '0;
    end else begin : g_next
      assign pin = gen_row[r-1].pout;
    end
    lm_row #(.AW(AW), .PW(PW), .SH(2*r)) u_row (
      .a_i(a_i),
      .b_i(b_i[2*r +: 2]),
      .p_i(pin),
      .p_o(pout)
    );
  end

  assign p_o = gen_row[NR-1].pout;

endmodule

// File: rtl/lut_mult.sv
module lut_mult #(
  parameter int IDX_W = 9,
  parameter int CW    = 12,
  parameter int OW    = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [OW-1:0]    op_i,
  input  logic             inv_i,
  output logic [CW+OW-1:0] res_o,
  output logic             vld_o
);
  localparam int HW  = OW / 2;
  localparam int HPW = CW + HW;
  localparam int RW  = CW + OW;

  // stage 1: table read
  logic [CW-1:0] coef, coef_q;
  logic [OW-1:0] op_q;
  logic          inv1_q, vld1_q;

  lm_rom #(.IDX_W(IDX_W), .CW(CW), .SW(4)) u_rom (
    .idx_i (idx_i),
    .coef_o(coef)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld1_q <= 1'b0;
      coef_q <= '0;
      op_q   <= '0;
      inv1_q <= 1'b0;
    end else begin
      vld1_q <= vld_i;
      if (vld_i) begin
        coef_q <= coef;
        op_q   <= op_i;
        inv1_q <= inv_i;
      end
    end
  end

  // stage 2: two half arrays
  logic [HPW-1:0] plo, phi, plo_q, phi_q;
  logic           inv2_q, vld2_q;

  lm_half #(.AW(CW), .BW(HW)) u_half_lo (
    .a_i(coef_q),
    .b_i(op_q[HW-1:0]),
    .p_o(plo)
  );
  lm_half #(.AW(CW), .BW(HW)) u_half_hi (
    .a_i(coef_q),
    .b_i(op_q[OW-1:HW]),
    .p_o(phi)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld2_q <= 1'b0;
      plo_q  <= '0;
      phi_q  <= '0;
      inv2_q <= 1'b0;
    end else begin
      vld2_q <= vld1_q;
      if (vld1_q) begin
        plo_q  <= plo;
        phi_q  <= phi;
        inv2_q <= inv1_q;
      end
    end
  end

  // stage 3: adder row and invert row
  logic [RW-1:0] sum;
  assign sum = RW'(plo_q) + (RW'(phi_q) << HW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      res_o <= '0;
    end else begin
      vld_o <= vld2_q;
      if (vld2_q) res_o <= sum ^ {RW{inv2_q}};
    end
  end

  // edges since reset, for windowed checks
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  a_r2_half_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld1_q |-> plo == HPW'(coef_q) * HPW'(op_q[HW-1:0]));

  a_r2_half_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld1_q |-> phi == HPW'(coef_q) * HPW'(op_q[OW-1:HW]));

  a_r4_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age_q == 2'd3 |-> vld_o == $past(vld_i, 3));

  a_r3_zero_operand: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && $past(vld_i, 3) && $past(op_i, 3) == '0)
      |-> res_o == {RW{$past(inv_i, 3)}});

  a_r7_index_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && $past(vld_i, 3) && $past(idx_i, 3) == '0)
      |-> res_o == {RW{$past(inv_i, 3)}});

  a_r6_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (!vld_o && res_o == '0));

endmodule

// File: tb/tb_lut_mult.sv
module tb_lut_mult;
  localparam int CLK_P = 10;
  localparam int IDX_W = 9;
  localparam int CW    = 12;
  localparam int OW    = 12;
  localparam int RW    = CW + OW;
  localparam int DEPTH = 1 << IDX_W;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             vld_i = 1'b0;
  logic [IDX_W-1:0] idx_i = '0;
  logic [OW-1:0]    op_i = '0;
  logic             inv_i = 1'b0;
  logic [RW-1:0]    res_o;
  logic             vld_o;

  lut_mult #(.IDX_W(IDX_W), .CW(CW), .OW(OW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .vld_i(vld_i), .idx_i(idx_i),
    .op_i(op_i), .inv_i(inv_i), .res_o(res_o), .vld_o(vld_o)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  // expected pipeline, index 2 is due now
  logic          e_v [3];
  logic [RW-1:0] e_r [3];
  string         e_t [3];

  function automatic logic [RW-1:0] coef_of(int i);
    return RW'((longint'(i) * longint'(2 * DEPTH - i) * 4095) / (longint'(DEPTH) * DEPTH));
  endfunction

  function automatic logic [RW-1:0] expect_res(int i, int op, bit inv);
    logic [RW-1:0] p;
    p = RW'(longint'(coef_of(i)) * op);
    return inv ? ~p : p;
  endfunction

  task automatic check(bit ok, string req, logic [RW-1:0] got, logic [RW-1:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic clear_model();
    for (int k = 0; k < 3; k++) begin
      e_v[k] = 1'b0; e_r[k] = '0; e_t[k] = "";
    end
  endtask

  task automatic cyc(bit v, int i, int op, bit inv, string tag);
    string t;
    @(negedge clk);
    check(vld_o === e_v[2], "R4", RW'(vld_o), RW'(e_v[2]));
    if (e_v[2]) check(res_o === e_r[2], e_t[2], res_o, e_r[2]);
    e_v[2] = e_v[1]; e_r[2] = e_r[1]; e_t[2] = e_t[1];
    e_v[1] = e_v[0]; e_r[1] = e_r[0]; e_t[1] = e_t[0];
    t = (v && i == 0) ? "R7" : tag;
    e_v[0] = v; e_r[0] = expect_res(i, op, inv); e_t[0] = t;
    vld_i = v; idx_i = IDX_W'(i); op_i = OW'(op); inv_i = inv;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    // R6 reset state
    check(vld_o === 1'b0, "R6", RW'(vld_o), '0);
    check(res_o === '0, "R6", res_o, '0);
    rst_ni = 1'b1;

    // R1 table contents through operand 1
    for (int i = 0; i < DEPTH; i++) cyc(1, i, 1, 0, "R1");
    // R2/R3 full-scale operand, inversion toggling
    for (int i = 0; i < DEPTH; i++) cyc(1, i, 4095, i[0], i[0] ? "R3" : "R2");
    // R5 operand sweep, inv alternates every cycle
    for (int op = 0; op < (1 << OW); op++) cyc(1, DEPTH - 1, op, op[0], "R5");
    // R2 half-only operands
    for (int i = 0; i < DEPTH; i += 7) begin
      cyc(1, i, 12'h03F, 0, "R2");
      cyc(1, i, 12'hFC0, 0, "R2");
      cyc(1, i, 12'hA5A, 1, "R3");
    end
    // R4 gaps in the valid stream
    for (int k = 0; k < 300; k++) cyc(k % 3 != 0, (k * 37) % DEPTH, (k * 97) % 4096, k[2], "R4");
    // R7 index zero with and without invert
    cyc(1, 0, 4095, 0, "R7");
    cyc(1, 0, 1234, 1, "R7");
    cyc(1, 511, 4095, 1, "R3");
    repeat (4) cyc(0, 0, 0, 0, "R4");

    // R6 asynchronous clear mid-stream
    cyc(1, 300, 4095, 1, "R3");
    cyc(1, 300, 4095, 1, "R3");
    cyc(1, 300, 4095, 1, "R3");
    cyc(1, 300, 4095, 1, "R3");
    #1;
    rst_ni = 1'b0;
    vld_i  = 1'b0;
    #1;
    check(vld_o === 1'b0, "R6", RW'(vld_o), '0);
    check(res_o === '0, "R6", res_o, '0);
    clear_model();
    @(negedge clk);
    rst_ni = 1'b1;
    for (int k = 0; k < 20; k++) cyc(1, k * 25, 4095 - k, k[0], k[0] ? "R3" : "R2");
    repeat (4) cyc(0, 0, 0, 0, "R4");
    finish_run();
  end

endmodule